// File: doc/BRIEF.md
# Acquisition Scan-List Sequencer

This block is the device-side control path for single-channel analog acquisition. A host programs it through two write targets: a byte-wide scan-list port and a command register. Bytes sent to the scan-list port are paired into 16-bit words and queued. Four queued words form one channel descriptor. After a start command, the sequencer moves each descriptor into a configuration pipe. From there it decodes the channel number, gain code and bank enables, and presents them to the converter side.

Conversions are paced by an external tick and are allowed only while the pacer is enabled. Each tick that arrives while a descriptor is held produces one conversion and consumes the descriptor. A behavioural front-end stub returns a sample, which is queued in a results FIFO that the host drains. A descriptor flagged as last ends the scan. Otherwise the next queued descriptor is loaded automatically. A six-bit status word reports FIFO occupancy, a sticky overrun, scan activity and pipe state.

Top module: `acq_seq`

## Requirements
- R1: A scan-list word is built from two writes to the scan-list port, low byte first and then high byte. Only bits 7:0 of each write count. A scan-list FIFO reset discards a pending low byte.
- R2: A command whose bits 15:3 are zero and whose bits 2:0 are nonzero is a reset. Bit 2 clears the scan-list FIFO, bit 1 clears the results FIFO and the overrun flag, and bit 0 empties the configuration pipe. The bits may be combined. After reset the status reads 6'b100000.
- R3: After a start command (0x0011), four queued words are moved into the configuration pipe, and status bit 4 (pipe full) is raised.
- R4: A pacer tick starts a conversion only while the pacer is enabled (0x0031) and a descriptor is held. Disabling the pacer (0x0030) makes ticks have no effect. Status bit 3 (scanning) is set while the pacer is enabled and a descriptor is held or a conversion is in flight.
- R5: The channel is group*4 + word2[7:6]. The group is {word3[6], word3[2], word3[1]}, so the codes 0x01, 0x02, 0x05, 0x06, 0x41 and 0x42 select groups 0 to 5. The gain is word3[5:3] and the bank enables are word3[1:0].
- R6: Each accepted tick pushes exactly one result into the results FIFO and empties the pipe. When word1 bit 2 (last) is set, scanning stops and later ticks produce nothing. Otherwise the next descriptor is loaded. The stub result is {channel, gain, 8-bit conversion serial number}.
- R7: Status bit 1 is set when the results FIFO holds data, and status bit 0 is set when it holds more than one sample. Status bit 5 is set when the scan-list FIFO is empty.
- R8: A push into a full results FIFO sets status bit 2 (overrun) and the sample is dropped. This bit is cleared only by a results-FIFO reset.
- R9: After a stop command (0x0010), no descriptor is moved into the pipe.
- R10: Command codes other than those listed above have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Write target: 0 command register, 1 scan-list byte port |
| host_wdata_i | input | 16 | Host write data |
| res_rd_i | input | 1 | Pop the results FIFO head |
| pacer_tick_i | input | 1 | Pacer tick |
| status_o | output | 6 | {sl_empty, pipe_full, scanning, overrun, has_data, more_than_one} |
| res_data_o | output | 16 | Results FIFO head |
| adc_conv_o | output | 1 | Conversion start pulse |
| adc_chan_o | output | 5 | Decoded channel |
| adc_gain_o | output | 3 | Decoded gain code |
| adc_bank_o | output | 2 | Bank enables {high, low} |
| adc_desc_o | output | 64 | Raw descriptor {word3, word2, word1, word0} |

## Verification
On every cycle, the assertions check the following: a conversion pulse appears only with the pacer on and a descriptor held; every conversion empties the pipe; the pipe fills only while the scan list runs; overrun stays set until a results reset; and the "more than one" flag implies "has data". The bench scenarios cover the rest. These include the byte pairing, the group-to-channel decode across all six groups, reloading between descriptors of a multi-entry scan, the last flag halting further ticks, stop and unknown commands, and the exact samples kept when the results FIFO overflows.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  localparam int WORD_W         = 16;
  localparam int WORDS_PER_DESC = 4;
  localparam int IDX_W          = $clog2(WORDS_PER_DESC);

  localparam logic [WORD_W-1:0] CMD_START    = 16'h0011;
  localparam logic [WORD_W-1:0] CMD_STOP     = 16'h0010;
  localparam logic [WORD_W-1:0] CMD_PACE_ON  = 16'h0031;
  localparam logic [WORD_W-1:0] CMD_PACE_OFF = 16'h0030;

  localparam int ST_MORE = 0;
  localparam int ST_HAS  = 1;
  localparam int ST_OVR  = 2;
  localparam int ST_SCAN = 3;
  localparam int ST_PIPE = 4;
  localparam int ST_SLE  = 5;
  localparam int ST_W    = 6;
endpackage

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign rd_ok   = pop_i && !flush_i && !empty_o;
  assign wr_ok   = push_i && !flush_i && (!full_o || rd_ok);
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= nxt(wp_q);
      if (rd_ok) rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
    end
  end
endmodule

// File: rtl/acq_afe_stub.sv
module acq_afe_stub (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        conv_i,
  input  logic [4:0]  chan_i,
  input  logic [2:0]  gain_i,
  output logic        valid_o,
  output logic [15:0] data_o
);
  logic [7:0] serial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      data_o   <= '0;
      serial_q <= '0;
    end else begin
      valid_o <= conv_i;
      if (conv_i) begin
        data_o   <= {chan_i, gain_i, serial_q};
        serial_q <= serial_q + 8'd1;
      end
    end
  end
endmodule

// File: rtl/acq_seq.sv
module acq_seq
  import acq_seq_pkg::*;
#(
  parameter int SL_DEPTH  = 16,
  parameter int RES_DEPTH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          host_wr_i,
  input  logic                          host_sel_i,
  input  logic [WORD_W-1:0]             host_wdata_i,
  input  logic                          res_rd_i,
  input  logic                          pacer_tick_i,
  output logic [ST_W-1:0]               status_o,
  output logic [WORD_W-1:0]             res_data_o,
  output logic                          adc_conv_o,
  output logic [4:0]                    adc_chan_o,
  output logic [2:0]                    adc_gain_o,
  output logic [1:0]                    adc_bank_o,
  output logic [WORDS_PER_DESC*WORD_W-1:0] adc_desc_o
);
  localparam int SL_CW  = $clog2(SL_DEPTH + 1);
  localparam int RES_CW = $clog2(RES_DEPTH + 1);

  // command decode
  logic ctl_wr, sl_wr, rst_cmd, rst_sl, rst_res, rst_pipe;
  logic cmd_start, cmd_stop, cmd_pon, cmd_poff;

  assign ctl_wr    = host_wr_i && !host_sel_i;
  assign sl_wr     = host_wr_i && host_sel_i;
  assign rst_cmd   = ctl_wr && (host_wdata_i[WORD_W-1:3] == '0) && (host_wdata_i[2:0] != 3'b000);
  assign rst_sl    = rst_cmd && host_wdata_i[2];
  assign rst_res   = rst_cmd && host_wdata_i[1];
  assign rst_pipe  = rst_cmd && host_wdata_i[0];
  assign cmd_start = ctl_wr && (host_wdata_i == CMD_START);
  assign cmd_stop  = ctl_wr && (host_wdata_i == CMD_STOP);
  assign cmd_pon   = ctl_wr && (host_wdata_i == CMD_PACE_ON);
  assign cmd_poff  = ctl_wr && (host_wdata_i == CMD_PACE_OFF);

  // byte pairing
  logic [7:0] lo_q;
  logic       half_q;
  logic       sl_push, sl_pop, sl_full, sl_empty;
  logic [WORD_W-1:0] sl_rdata;
  logic [SL_CW-1:0]  sl_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      half_q <= 1'b0;
    end else if (rst_sl) begin
      half_q <= 1'b0;
    end else if (sl_wr) begin
      half_q <= !half_q;
      if (!half_q) lo_q <= host_wdata_i[7:0];
    end
  end

  assign sl_push = sl_wr && half_q && !sl_full;

  acq_fifo #(.W(WORD_W), .DEPTH(SL_DEPTH)) u_sl_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_sl),
    .push_i  (sl_push),
    .pop_i   (sl_pop),
    .wdata_i ({host_wdata_i[7:0], lo_q}),
    .rdata_o (sl_rdata),
    .count_o (sl_cnt),
    .full_o  (sl_full),
    .empty_o (sl_empty)
  );

  // configuration pipe and sequencing
  logic [WORD_W-1:0] w_q [WORDS_PER_DESC];
  logic [IDX_W-1:0]  widx_q;
  logic run_q, pace_q, pipe_full_q, busy_q, ovr_q;
  logic load, last;
  logic [2:0] grp;

  assign load   = run_q && !pipe_full_q && !sl_empty &&
                  ((widx_q != '0) || (sl_cnt >= SL_CW'(WORDS_PER_DESC)));
  assign sl_pop = load;

  assign grp        = {w_q[3][6], w_q[3][2], w_q[3][1]};
  assign adc_chan_o = {grp, w_q[2][7:6]};
  assign adc_gain_o = w_q[3][5:3];
  assign adc_bank_o = w_q[3][1:0];
  assign last       = w_q[1][2];

  generate
    for (genvar g = 0; g < WORDS_PER_DESC; g++) begin : g_desc
      assign adc_desc_o[g*WORD_W +: WORD_W] = w_q[g];
    end
  endgenerate

  assign adc_conv_o = pacer_tick_i && pace_q && pipe_full_q && !busy_q;

  logic              afe_valid;
  logic [WORD_W-1:0] afe_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q       <= 1'b0;
      pace_q      <= 1'b0;
      pipe_full_q <= 1'b0;
      busy_q      <= 1'b0;
      widx_q      <= '0;
      for (int i = 0; i < WORDS_PER_DESC; i++) w_q[i] <= '0;
    end else begin
      if (adc_conv_o && last) run_q <= 1'b0;
      if (cmd_start) run_q <= 1'b1;
      if (cmd_stop)  run_q <= 1'b0;
      if (cmd_pon)   pace_q <= 1'b1;
      if (cmd_poff)  pace_q <= 1'b0;

      if (adc_conv_o)     busy_q <= 1'b1;
      else if (afe_valid) busy_q <= 1'b0;

      if (rst_pipe) begin
        pipe_full_q <= 1'b0;
        widx_q      <= '0;
      end else if (adc_conv_o) begin
        pipe_full_q <= 1'b0;
      end else if (load) begin
        w_q[widx_q] <= sl_rdata;
        widx_q      <= widx_q + 1'b1;
        if (widx_q == IDX_W'(WORDS_PER_DESC - 1)) pipe_full_q <= 1'b1;
      end
    end
  end

  acq_afe_stub u_afe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .conv_i  (adc_conv_o),
    .chan_i  (adc_chan_o),
    .gain_i  (adc_gain_o),
    .valid_o (afe_valid),
    .data_o  (afe_data)
  );

  // results
  logic [RES_CW-1:0] res_cnt;
  logic              res_full, res_empty;

  acq_fifo #(.W(WORD_W), .DEPTH(RES_DEPTH)) u_res_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rst_res),
    .push_i  (afe_valid),
    .pop_i   (res_rd_i),
    .wdata_i (afe_data),
    .rdata_o (res_data_o),
    .count_o (res_cnt),
    .full_o  (res_full),
    .empty_o (res_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ovr_q <= 1'b0;
    else if (rst_res)                         ovr_q <= 1'b0;
    else if (afe_valid && res_full && !res_rd_i) ovr_q <= 1'b1;
  end

  assign status_o[ST_MORE] = (res_cnt > RES_CW'(1));
  assign status_o[ST_HAS]  = !res_empty;
  assign status_o[ST_OVR]  = ovr_q;
  assign status_o[ST_SCAN] = pace_q && (pipe_full_q || busy_q);
  assign status_o[ST_PIPE] = pipe_full_q;
  assign status_o[ST_SLE]  = sl_empty;
endmodule

// File: rtl/acq_seq_chk.sv
module acq_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_wr_i,
  input logic        host_sel_i,
  input logic [15:0] host_wdata_i,
  input logic        more_i,
  input logic        has_i,
  input logic        ovr_i,
  input logic        pipe_i,
  input logic        adc_conv_o,
  input logic        run_q,
  input logic        pace_q
);
  logic res_reset;
  assign res_reset = host_wr_i && !host_sel_i &&
                     ((host_wdata_i & 16'hFFFA) == 16'h0002);

  // R4
  a_r4_conv_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |-> (pace_q && pipe_i));

  // R6
  a_r6_conv_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |=> !pipe_i);

  // R3
  a_r3_fill_when_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pipe_i) |-> $past(run_q));

  // R8
  a_r8_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_i && !res_reset) |=> ovr_i);

  // R7
  a_r7_more_has: assert property (@(posedge clk_i) disable iff (!rst_ni)
    more_i |-> has_i);
endmodule

bind acq_seq acq_seq_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .host_wr_i    (host_wr_i),
  .host_sel_i   (host_sel_i),
  .host_wdata_i (host_wdata_i),
  .more_i       (status_o[0]),
  .has_i        (status_o[1]),
  .ovr_i        (status_o[2]),
  .pipe_i       (status_o[4]),
  .adc_conv_o   (adc_conv_o),
  .run_q        (run_q),
  .pace_q       (pace_q)
);

// File: tb/test_acq_seq.sv
module test_acq_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {chan[4:0], gain[2:0], bank[1:0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {5'd0,  3'd0, 2'b01}, {5'd5,  3'd1, 2'b10}, {5'd9,  3'd2, 2'b01},
    {5'd14, 3'd3, 2'b10}, {5'd17, 3'd4, 2'b01}, {5'd23, 3'd7, 2'b10},
    {5'd3,  3'd5, 2'b01}, {5'd20, 3'd6, 2'b10}};

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_sel = 0, res_rd = 0, pacer_tick = 0;
  logic [15:0] host_wdata = '0;
  logic [5:0]  status;
  logic [15:0] res_data;
  logic        adc_conv;
  logic [4:0]  adc_chan;
  logic [2:0]  adc_gain;
  logic [1:0]  adc_bank;
  logic [63:0] adc_desc;

  int checks = 0, errors = 0, conv_total = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_seq i_acq_seq (
    .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_sel_i(host_sel),
    .host_wdata_i(host_wdata), .res_rd_i(res_rd), .pacer_tick_i(pacer_tick),
    .status_o(status), .res_data_o(res_data), .adc_conv_o(adc_conv),
    .adc_chan_o(adc_chan), .adc_gain_o(adc_gain), .adc_bank_o(adc_bank),
    .adc_desc_o(adc_desc));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_w(input logic sel, input logic [15:0] d);
    @(negedge clk); host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic put_word(input logic [15:0] w);
    host_w(1'b1, {8'hA5, w[7:0]});
    host_w(1'b1, {8'h3C, w[15:8]});
  endtask

  function automatic logic [7:0] grp_code(input int g);
    case (g)
      0: return 8'h01; 1: return 8'h02; 2: return 8'h05;
      3: return 8'h06; 4: return 8'h41; default: return 8'h42;
    endcase
  endfunction

  task automatic put_desc(input logic [4:0] ch, input logic [2:0] g, input bit last);
    put_word(16'h0000);
    put_word(last ? 16'h0004 : 16'h0000);
    put_word(16'h0800 | {8'h00, ch[1:0], 6'b0});
    put_word(16'hC000 | {10'b0, g, 3'b0} | {8'h00, grp_code(int'(ch) / 4)});
  endtask

  task automatic tick(output logic c, output logic [4:0] ch,
                      output logic [2:0] g, output logic [1:0] b);
    @(negedge clk); pacer_tick = 1; #1;
    c = adc_conv; ch = adc_chan; g = adc_gain; b = adc_bank;
    @(negedge clk); pacer_tick = 0;
    if (c) conv_total++;
  endtask

  task automatic pop();
    @(negedge clk); res_rd = 1; @(negedge clk); res_rd = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic c; logic [4:0] ch; logic [2:0] g; logic [1:0] b;
    logic [15:0] exp_d, exp_first;
    wait_n(3); rst_n = 1; wait_n(1);
    chk("R2 reset status", status, 6'b100000);
    chk("R4 no conv after reset", adc_conv, 0);

    // table walk: single acquisitions
    for (int i = 0; i < NVEC; i++) begin
      logic [4:0] vc; logic [2:0] vg; logic [1:0] vb;
      {vc, vg, vb} = VEC[i];
      put_desc(vc, vg, 1'b1);
      host_w(1'b0, 16'h0011);
      wait_n(6);
      chk("R3 pipe full after start", status[4], 1);
      chk("R7 scan-list empty after load", status[5], 1);
      host_w(1'b0, 16'h0031);
      chk("R4 scanning flag", status[3], 1);
      exp_d = {vc, vg, 8'(conv_total)};
      tick(c, ch, g, b);
      chk("R6 conversion on tick", c, 1);
      chk("R5 channel decode", ch, vc);
      chk("R5 gain decode", g, vg);
      chk("R5 bank decode", b, vb);
      wait_n(1);
      chk("R6 result data", res_data, exp_d);
      chk("R7 has data", status[1:0], 2'b10);
      tick(c, ch, g, b);
      chk("R6 last stops further ticks", c, 0);
      pop();
      host_w(1'b0, 16'h0030);
      chk("R7 drained", status, 6'b100000);
    end

    // R4: pacer disabled ignores ticks
    put_desc(5'd6, 3'd1, 1'b1);
    host_w(1'b0, 16'h0011);
    wait_n(6);
    tick(c, ch, g, b);
    chk("R4 tick ignored with pacer off", c, 0);
    wait_n(2);
    chk("R4 pipe kept, no result", status, 6'b110000);
    host_w(1'b0, 16'h0031);
    host_w(1'b0, 16'h0030);
    tick(c, ch, g, b);
    chk("R4 tick ignored after pacer disabled", c, 0);
    host_w(1'b0, 16'h0031);
    exp_d = {5'd6, 3'd1, 8'(conv_total)};
    tick(c, ch, g, b);
    chk("R4 conversion once pacer on", c, 1);
    wait_n(1);
    chk("R6 result after enable", res_data, exp_d);
    pop();

    // R6: two-entry scan, reload between ticks
    put_desc(5'd10, 3'd2, 1'b0);
    put_desc(5'd21, 3'd3, 1'b1);
    host_w(1'b0, 16'h0011);
    wait_n(6);
    exp_first = {5'd10, 3'd2, 8'(conv_total)};
    tick(c, ch, g, b);
    chk("R6 first entry channel", ch, 10);
    wait_n(6);
    chk("R6 next entry reloaded", status[4], 1);
    exp_d = {5'd21, 3'd3, 8'(conv_total)};
    tick(c, ch, g, b);
    chk("R6 second entry channel", ch, 21);
    wait_n(6);
    chk("R6 pipe empty after last", status[4], 0);
    tick(c, ch, g, b);
    chk("R6 no conv after last", c, 0);
    chk("R7 more than one sample", status[1:0], 2'b11);
    chk("R6 first result", res_data, exp_first);
    pop();
    chk("R6 second result", res_data, exp_d);
    pop();
    chk("R7 empty after pops", status[1:0], 2'b00);
    host_w(1'b0, 16'h0030);

    // R9: stop prevents loading
    host_w(1'b0, 16'h0011);
    host_w(1'b0, 16'h0010);
    put_desc(5'd1, 3'd0, 1'b1);
    wait_n(8);
    chk("R9 no load after stop", status[5:4], 2'b00);
    host_w(1'b0, 16'h0004);
    chk("R2 scan-list reset", status, 6'b100000);

    // R10: unknown codes ignored
    host_w(1'b0, 16'h0011);
    put_desc(5'd2, 3'd0, 1'b1);
    wait_n(6);
    chk("R3 loaded", status, 6'b110000);
    host_w(1'b0, 16'h0055);
    host_w(1'b0, 16'h0008);
    host_w(1'b0, 16'h0012);
    host_w(1'b0, 16'h0020);
    chk("R10 unknown codes no effect", status, 6'b110000);
    host_w(1'b0, 16'h0001);
    chk("R2 pipe reset", status, 6'b100000);
    host_w(1'b0, 16'h0010);

    // R1: pending low byte discarded by scan-list reset
    host_w(1'b1, 16'h00EE);
    host_w(1'b0, 16'h0004);
    put_desc(5'd13, 3'd2, 1'b1);
    host_w(1'b0, 16'h0011);
    wait_n(6);
    host_w(1'b0, 16'h0031);
    tick(c, ch, g, b);
    chk("R1 channel after stray byte reset", ch, 13);
    chk("R1 gain after stray byte reset", g, 2);
    chk("R1 bank after stray byte reset", b, 2'b10);
    chk("R1 raw word3 from byte pairs", adc_desc[63:48], 16'hC016);
    wait_n(1);
    pop();

    // R8: overrun
    for (int k = 0; k < 5; k++) begin
      put_desc(5'(k + 1), 3'(k), 1'b1);
      host_w(1'b0, 16'h0011);
      wait_n(6);
      if (k == 0) exp_first = {5'd1, 3'd0, 8'(conv_total)};
      tick(c, ch, g, b);
      wait_n(2);
      if (k == 3) chk("R8 full without overrun", status[2:0], 3'b011);
    end
    chk("R8 overrun set", status[2:0], 3'b111);
    chk("R8 oldest sample kept", res_data, exp_first);
    host_w(1'b0, 16'h0001);
    chk("R8 overrun survives pipe reset", status[2], 1);
    host_w(1'b0, 16'h0002);
    chk("R8 results reset clears", status[2:0], 3'b000);
    host_w(1'b0, 16'h0030);

    // R2: combined reset
    put_desc(5'd4, 3'd1, 1'b1);
    chk("R7 scan-list not empty", status[5], 0);
    host_w(1'b0, 16'h0007);
    chk("R2 combined reset", status, 6'b100000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule